// File: doc/BRIEF.md
# Synchronizable Word-Rate Timing Generator

This block sits beside a parallel-to-serial or serial-to-parallel datapath and derives all of its word-rate timing from the fast bit clock. A 3-bit ratio select picks the word length n. The block then emits a one-cycle load strobe once per word. It also produces a low-speed clock level at the word rate, which may be slowed to half that rate, and a copy of that clock delayed by a selectable number of eighths of its period.

The divider stays idle after reset until it sees a rising edge on an asynchronous alignment input. That edge fixes the word boundary. A warm-up window of 2n fast cycles follows, during which a flag tells the datapath to treat its parallel word as zero. Load strobes then begin. A later rising edge that lands off the current word boundary re-aligns the divider and starts a fresh warm-up. An edge that lands on the boundary changes nothing. Several instances can therefore be locked to one shared word clock, either by feeding one instance's low-speed clock to the others or by driving all of them from a free-running word-rate clock.

Top module: `modulus_timing_gen`

## Requirements
- R1: While `rst` is high, and after it falls until an alignment edge has been seen, `load_stb`, `ls_clk` and `ls_clk_rot` are 0 and `zero_in` is 1.
- R2: The word length n for `mod_sel` codes 0 through 7 is 4, 5, 8, 10, 16, 20, 32 and 40, and consecutive load strobes are exactly n cycles apart.
- R3: `sync_in` passes through a two-flop synchronizer. If `sync_in` is first sampled high at clock edge k+1, after being low, then the word boundary (position 0) is the cycle that starts at edge k+3.
- R4: `load_stb` is high for exactly one cycle. The first strobe is in the cycle that starts 2n cycles after the word boundary, and strobes then repeat every n cycles.
- R5: `zero_in` is high from the word boundary until the first load strobe, and low from the first strobe onward. No strobe occurs while it is high.
- R6: With `half_rate` low, `ls_clk` runs from the word boundary with period n. It is high for the first ceil(n/2) cycles of each word, so for odd n it is high for (n+1)/2 cycles.
- R7: With `half_rate` high, `ls_clk` has period P = 2n. It is high for the first n cycles of each pair of words, counted from the word boundary.
- R8: `ls_clk_rot` equals `ls_clk` delayed, cyclically, by `phase_sel`×P/8 cycles, where P is the `ls_clk` period. When P is not a multiple of 8, the delay is zero and `ls_clk_rot` equals `ls_clk`. This always applies for n = 5 and n = 10.
- R9: A later rising edge whose synchronized edge falls in a cycle that is not the last position (n−1) of a word re-aligns the divider. Strobes stop, `zero_in` rises, and a new boundary and a new 2n warm-up follow, with the same timing as R3 and R4.
- R10: A rising edge whose synchronized edge falls on position n−1 has no effect. A free-running clock of period n on `sync_in` keeps strobes every n cycles without a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 3 | Word-length code (R2) |
| sync_in | input | 1 | Asynchronous alignment input; rising edges start or re-align the divider |
| half_rate | input | 1 | High halves the low-speed clock rate |
| phase_sel | input | 3 | Delay of the rotated clock, in eighths of its period |
| load_stb | output | 1 | One-cycle word load strobe |
| zero_in | output | 1 | High while the datapath must treat its parallel word as zero |
| ls_clk | output | 1 | Low-speed clock level |
| ls_clk_rot | output | 1 | Phase-rotated low-speed clock level |

## Verification
On every cycle, the bound checker enforces the properties that hold for any configuration. It checks that strobes are single-cycle and spaced n apart within an uninterrupted run, that no strobe occurs in warm-up, that the first strobe coincides with the end of warm-up, and that rotation is bypassed for n = 5 and n = 10. Only the bench scenarios can show the absolute timing: the exact cycle of the first strobe after an alignment edge, the duty cycle and phase lag of both clock outputs for each ratio, and the different treatment of an off-boundary edge and an on-boundary edge.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int SEL_W = 3;
  localparam int NMAX  = 40;
  localparam int CNT_W = $clog2(2 * NMAX + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_WARM, ST_RUN} tg_state_e;

  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return CNT_W'(4);
      3'd1:    return CNT_W'(5);
      3'd2:    return CNT_W'(8);
      3'd3:    return CNT_W'(10);
      3'd4:    return CNT_W'(16);
      3'd5:    return CNT_W'(20);
      3'd6:    return CNT_W'(32);
      default: return CNT_W'(40);
    endcase
  endfunction
endpackage

// File: rtl/tgen_sync_edge.sv
module tgen_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/tgen_divider.sv
module tgen_divider
  import tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [SEL_W-1:0] mod_sel,
  output logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] nxt_pos,
  output logic             nxt_half,
  output tg_state_e        nxt_state
);
  logic [CNT_W-1:0] pos, lk, nxt_lk;
  logic             half;
  tg_state_e        state;
  logic             at_end;

  assign ratio  = ratio_of(mod_sel);
  assign at_end = (pos >= ratio - 1'b1);

  always_comb begin
    nxt_pos   = at_end ? '0 : pos + 1'b1;
    nxt_half  = at_end ? ~half : half;
    nxt_state = state;
    nxt_lk    = lk;
    if (state == ST_IDLE) begin
      nxt_pos  = '0;
      nxt_half = 1'b0;
    end
    if (state == ST_WARM) begin
      nxt_lk = lk + 1'b1;
      if (lk == (ratio << 1) - 1'b1) nxt_state = ST_RUN;
    end
    // an edge off the word boundary (or the very first edge) re-aligns
    if (rise && (state == ST_IDLE || pos != ratio - 1'b1)) begin
      nxt_pos   = '0;
      nxt_half  = 1'b0;
      nxt_lk    = '0;
      nxt_state = ST_WARM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      half  <= 1'b0;
      lk    <= '0;
      state <= ST_IDLE;
    end else begin
      pos   <= nxt_pos;
      half  <= nxt_half;
      lk    <= nxt_lk;
      state <= nxt_state;
    end
  end
endmodule

// File: rtl/tgen_clk_shape.sv
module tgen_clk_shape
  import tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ratio,
  input  logic [CNT_W-1:0] nxt_pos,
  input  logic             nxt_half,
  input  tg_state_e        nxt_state,
  input  logic             half_rate,
  input  logic [SEL_W-1:0] phase_sel,
  output logic             load_stb,
  output logic             zero_in,
  output logic             ls_clk,
  output logic             ls_clk_rot
);
  logic [CNT_W-1:0]       per, q, hi, step, off, qr;
  logic [CNT_W+SEL_W-1:0] off_w;
  logic                   active;

  always_comb begin
    per    = half_rate ? (ratio << 1) : ratio;
    q      = (half_rate && nxt_half) ? ratio + nxt_pos : nxt_pos;
    hi     = (per + 1'b1) >> 1;
    step   = (per[2:0] == 3'b000) ? (per >> 3) : '0;
    off_w  = phase_sel * step;
    off    = off_w[CNT_W-1:0];
    qr     = (q >= off) ? q - off : q + per - off;
    active = (nxt_state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_stb   <= 1'b0;
      zero_in    <= 1'b1;
      ls_clk     <= 1'b0;
      ls_clk_rot <= 1'b0;
    end else begin
      load_stb   <= (nxt_state == ST_RUN) && (nxt_pos == '0);
      zero_in    <= (nxt_state != ST_RUN);
      ls_clk     <= active && (q < hi);
      ls_clk_rot <= active && (qr < hi);
    end
  end
endmodule

// File: rtl/modulus_timing_gen.sv
module modulus_timing_gen
  import tgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mod_sel,
  input  logic       sync_in,
  input  logic       half_rate,
  input  logic [2:0] phase_sel,
  output logic       load_stb,
  output logic       zero_in,
  output logic       ls_clk,
  output logic       ls_clk_rot
);
  logic             rise;
  logic [CNT_W-1:0] ratio, nxt_pos;
  logic             nxt_half;
  tg_state_e        nxt_state;

  tgen_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(sync_in), .rise(rise)
  );

  tgen_divider u_div (
    .clk(clk), .rst(rst), .rise(rise), .mod_sel(mod_sel),
    .ratio(ratio), .nxt_pos(nxt_pos), .nxt_half(nxt_half), .nxt_state(nxt_state)
  );

  tgen_clk_shape u_shape (
    .clk(clk), .rst(rst), .ratio(ratio), .nxt_pos(nxt_pos), .nxt_half(nxt_half),
    .nxt_state(nxt_state), .half_rate(half_rate), .phase_sel(phase_sel),
    .load_stb(load_stb), .zero_in(zero_in), .ls_clk(ls_clk), .ls_clk_rot(ls_clk_rot)
  );
endmodule

// File: rtl/modulus_timing_gen_chk.sv
module modulus_timing_gen_chk
  import tgen_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] mod_sel,
  input logic       load_stb,
  input logic       zero_in,
  input logic       ls_clk,
  input logic       ls_clk_rot
);
  logic [7:0] gap;
  logic       seen, intr;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 8'd0;
      seen <= 1'b0;
      intr <= 1'b0;
    end else if (load_stb) begin
      gap  <= 8'd1;
      seen <= 1'b1;
      intr <= 1'b0;
    end else begin
      if (gap != 8'hFF) gap <= gap + 8'd1;
      if (zero_in) intr <= 1'b1;
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && seen && !intr) |-> (gap == 8'(ratio_of(mod_sel))));

  // R5
  warm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    zero_in |-> !load_stb);

  // R5
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(zero_in) |-> load_stb);

  // R8
  rot_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mod_sel) == 3'd1 || $past(mod_sel) == 3'd3) |-> (ls_clk_rot == ls_clk));
endmodule

bind modulus_timing_gen modulus_timing_gen_chk i_chk (
  .clk(clk), .rst(rst), .mod_sel(mod_sel), .load_stb(load_stb),
  .zero_in(zero_in), .ls_clk(ls_clk), .ls_clk_rot(ls_clk_rot)
);

// File: tb/test_modulus_timing_gen.sv
`timescale 1ns/1ps
module test_modulus_timing_gen;
  logic       clk = 1'b0, rst = 1'b1, sync_in = 1'b0, half_rate = 1'b0;
  logic [2:0] mod_sel = 3'd0, phase_sel = 3'd0;
  logic       load_stb, zero_in, ls_clk, ls_clk_rot;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  bit model_on = 0, done = 0;
  int ref_start = 0, cur_n = 4, cur_ph = 0;
  bit cur_half = 0;
  int nt[8] = '{4, 5, 8, 10, 16, 20, 32, 40};   // R2 table

  modulus_timing_gen i_modulus_timing_gen (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .sync_in(sync_in),
    .half_rate(half_rate), .phase_sel(phase_sel), .load_stb(load_stb),
    .zero_in(zero_in), .ls_clk(ls_clk), .ls_clk_rot(ls_clk_rot)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: scoreboard for strobes plus a per-cycle clock model
  always @(negedge clk) begin
    int e, j, per, q, hi, step, off, qr;
    bit el, er, ez;
    if (!rst) begin
      if (load_stb) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected load strobe", cyc, -1);
        else begin
          e = exp_q.pop_front();
          chk(cyc == e, "R3/R4 strobe cycle", cyc, e);
        end
      end
      if (model_on && cyc >= ref_start) begin
        j    = cyc - ref_start;
        per  = cur_half ? 2 * cur_n : cur_n;
        q    = j % per;
        hi   = (per + 1) / 2;
        el   = (q < hi);
        step = (per % 8 == 0) ? per / 8 : 0;
        off  = cur_ph * step;
        qr   = (q - off + per) % per;
        er   = (qr < hi);
        ez   = (j < 2 * cur_n);
        chk(ls_clk == el, cur_half ? "R7 half-rate ls_clk" : "R6 ls_clk", ls_clk, el);
        chk(ls_clk_rot == er, "R8 rotated clock", ls_clk_rot, er);
        chk(zero_in == ez, "R5 zero_in", zero_in, ez);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    model_on = 0;
    rst = 1; sync_in = 0;
    repeat (2) @(negedge clk);
    chk(load_stb == 0 && ls_clk == 0 && ls_clk_rot == 0, "R1 outputs in reset",
        {load_stb, ls_clk, ls_clk_rot}, 0);
    chk(zero_in == 1, "R1 zero_in in reset", zero_in, 1);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(load_stb == 0 && ls_clk == 0 && zero_in == 1, "R1 idle without edge",
        {load_stb, ls_clk, zero_in}, 1);
  endtask

  task automatic scn(input int sel, input bit hr, input int ph, input int words);
    int c0, n;
    do_reset();
    mod_sel = 3'(sel); half_rate = hr; phase_sel = 3'(ph);
    n = nt[sel];
    @(negedge clk);
    c0 = cyc;
    sync_in = 1;
    cur_n = n; cur_half = hr; cur_ph = ph; ref_start = c0 + 3;
    model_on = 1;
    for (int k = 0; k < words; k++) exp_q.push_back(c0 + 3 + 2 * n + k * n);
    wait_until(c0 + 3 + 2 * n + (words - 1) * n + 1);
    model_on = 0;
    chk(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 0);
  endtask

  initial begin
    int c0;
    do_reset();
    for (int s = 0; s < 8; s++) scn(s, 0, 0, 4);   // R2 R6 ratio sweep
    scn(2, 0, 3, 3);    // R8 lag of 3 cycles
    scn(2, 1, 2, 3);    // R7 R8 half rate, lag 4
    scn(0, 1, 7, 4);    // R7 R8 lag 7 of period 8
    scn(1, 0, 5, 3);    // R8 no rotation for n=5
    scn(3, 1, 6, 2);    // R8 no rotation for n=10
    scn(0, 0, 2, 3);    // R8 period 4 is not a multiple of 8

    // R9: misaligned re-edge with n=8
    do_reset();
    mod_sel = 3'd2; half_rate = 0; phase_sel = 3'd0;
    @(negedge clk);
    c0 = cyc;
    sync_in = 1;
    exp_q.push_back(c0 + 19);
    exp_q.push_back(c0 + 27);
    wait_until(c0 + 25); sync_in = 0;
    wait_until(c0 + 30); sync_in = 1;
    exp_q.push_back(c0 + 49);
    exp_q.push_back(c0 + 57);
    wait_until(c0 + 40);
    chk(zero_in == 1, "R9 zero_in after re-align", zero_in, 1);
    wait_until(c0 + 58);
    chk(exp_q.size() == 0, "R9 strobes after re-align", exp_q.size(), 0);
    chk(zero_in == 0, "R9 zero_in after new warm-up", zero_in, 0);

    // R10: free-running word-rate clock on sync_in, n=4
    do_reset();
    mod_sel = 3'd0; half_rate = 0; phase_sel = 3'd0;
    @(negedge clk);
    c0 = cyc;
    cur_n = 4; cur_half = 0; cur_ph = 0; ref_start = c0 + 3;
    model_on = 1;
    for (int k = 0; k < 8; k++) exp_q.push_back(c0 + 11 + 4 * k);
    for (int m = 0; m < 10; m++) begin
      wait_until(c0 + 4 * m);     sync_in = 1;
      wait_until(c0 + 4 * m + 2); sync_in = 0;
    end
    wait_until(c0 + 41);
    model_on = 0;
    chk(exp_q.size() == 0, "R10 unbroken strobes", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (all) actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule